// File: doc/BRIEF.md
# Programmable Raster Timing and Fetch-Address Generator

This block is the timing core of a display controller. A horizontal counter and a vertical counter run continuously with totals taken from registers. From their values it decodes sync pulses, a border rectangle and a display window. For every word position inside the window it issues a framebuffer word address with a strobe. Software sets the geometry through a simple register write port. All geometry and mode settings except display enable are copied into shadow registers once per frame, so a reprogramming never tears a frame.

Interlaced output works by alternating between two field base addresses, one per field. After each displayed line the address steps by the words in a line plus a programmable modulo minus one, so a field can skip every other stored line. Each field also has its own vertical window start. Every output is registered and shows the counter position of the previous clock. The fetch side is a three-state machine: `FS_IDLE` waits for the first window word of a line, `FS_BURST` issues the remaining words, and `FS_HOLD` covers the rest of the line. The transitions are IDLE→BURST on the first window word, IDLE→HOLD for a one-word line, BURST→HOLD on the last word, HOLD→IDLE and BURST→IDLE at the end of a line, and any state→IDLE at the end of a line.

Top module: `raster_fetch_gen`

## Requirements
- R1: The horizontal counter counts 0..HTOT and then wraps. The vertical counter advances on each horizontal wrap and wraps after VTOT, so a frame lasts (HTOT+1)*(VTOT+1) clocks. Every output shows the counter position of the previous clock.
- R2: hsync is active while h < HSW, and vsync is active while v < VSW, with HSW in SYNCW[15:0] and VSW in SYNCW[31:16]. MODE bit 2 inverts hsync and MODE bit 3 inverts vsync.
- R3: border_o is high when h lies in [HBS, HBE) and v lies in [VBS, VBE), the position is outside the display window, and display is enabled. Start values are held in bits [31:16] of the border registers and stop values in bits [15:0].
- R4: The window covers h in [HWS, HWS+WORDS+1) and v in [VS, VS+LINES+1). VS is VWIN[15:0] in field 0 and VWIN[31:16] in field 1. pixel_o is high inside the window when display is enabled.
- R5: fetch_stb_o pulses once per window word, only when display is enabled, and fetch_addr_o is the line start plus the word index.
- R6: After the last word of a line, the next line start is the previous start plus WORDS+1 plus MOD-1.
- R7: The first window line of a field starts at BASE_L in field 0 and at BASE_S in field 1. These are reloaded in every field.
- R8: When interlace (MODE bit 1) is in effect, the field id toggles at each frame wrap. Otherwise it is 0.
- R9: Clearing display enable (MODE bit 0) takes effect on the next clock. It forces pixel_o, border_o and fetch_stb_o low while the counters and syncs keep running.
- R10: All registers except display enable take effect only from the first clock of the next frame.
- R11: Reset clears display enable, drives all outputs low and restores the default timing parameters in both the live and the shadow registers.
- R12: Register indices are HTOT 0, VTOT 1, HBRD 2, VBRD 3, HWIN 4, VWIN 5, WORDS 6, LINES 7, MOD 8, BASE_L 9, BASE_S 10, SYNCW 11, MODE 12. A write to any other index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| border_o | output | 1 | Border colour region |
| pixel_o | output | 1 | Display window pixel active |
| field_o | output | 1 | Field id |
| fetch_stb_o | output | 1 | Word fetch strobe |
| fetch_addr_o | output | AW | Framebuffer word address |

## Verification
The bench builds the block with a 16-by-10 raster and a 4-word by 4-line window, using HW=VW=10 and AW=16. These default parameters make one frame 160 clocks long. As a result, frame wraps, shadow reloads on frame boundaries, field alternation over several frames, and a mid-run reset back to defaults all occur within a few thousand cycles. A base of 0x100, a second field base of 0x200 and a modulo of 5 keep every expected address distinct.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int unsigned REG_HTOT   = 0;
    localparam int unsigned REG_VTOT   = 1;
    localparam int unsigned REG_HBRD   = 2;
    localparam int unsigned REG_VBRD   = 3;
    localparam int unsigned REG_HWIN   = 4;
    localparam int unsigned REG_VWIN   = 5;
    localparam int unsigned REG_WORDS  = 6;
    localparam int unsigned REG_LINES  = 7;
    localparam int unsigned REG_MOD    = 8;
    localparam int unsigned REG_BASE_L = 9;
    localparam int unsigned REG_BASE_S = 10;
    localparam int unsigned REG_SYNCW  = 11;
    localparam int unsigned REG_MODE   = 12;

    localparam int unsigned MODE_EN    = 0;
    localparam int unsigned MODE_ILACE = 1;
    localparam int unsigned MODE_HPOL  = 2;
    localparam int unsigned MODE_VPOL  = 3;

    // upper field of a packed pair register starts here
    localparam int unsigned HI_LSB = 16;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_BURST = 2'd1,
        FS_HOLD  = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
#(
    parameter int HW = 10,
    parameter int VW = 10,
    parameter int AW = 22,
    parameter int DEF_HTOT = 857,
    parameter int DEF_VTOT = 524,
    parameter int DEF_HBS = 126,
    parameter int DEF_HBE = 837,
    parameter int DEF_VBS = 40,
    parameter int DEF_VBE = 444,
    parameter int DEF_HWS = 164,
    parameter int DEF_VWS = 36,
    parameter int DEF_WORDS = 319,
    parameter int DEF_LINES = 479,
    parameter int DEF_MOD = 1,
    parameter int DEF_BASE_L = 0,
    parameter int DEF_BASE_S = 320,
    parameter int DEF_HSW = 64,
    parameter int DEF_VSW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [31:0]   wdata,
    input  logic          frame_end,
    output logic          en,
    output logic [HW-1:0] htot_s,
    output logic [VW-1:0] vtot_s,
    output logic [HW-1:0] hbs_s,
    output logic [HW-1:0] hbe_s,
    output logic [VW-1:0] vbs_s,
    output logic [VW-1:0] vbe_s,
    output logic [HW-1:0] hws_s,
    output logic [VW-1:0] vw1_s,
    output logic [VW-1:0] vw2_s,
    output logic [HW-1:0] words_s,
    output logic [VW-1:0] lines_s,
    output logic [HW-1:0] mod_s,
    output logic [AW-1:0] basel_s,
    output logic [AW-1:0] bases_s,
    output logic [HW-1:0] hsw_s,
    output logic [VW-1:0] vsw_s,
    output logic          ilace_s,
    output logic          hpol_s,
    output logic          vpol_s
);
    logic [HW-1:0] htot_l, hbs_l, hbe_l, hws_l, words_l, mod_l, hsw_l;
    logic [VW-1:0] vtot_l, vbs_l, vbe_l, vw1_l, vw2_l, lines_l, vsw_l;
    logic [AW-1:0] basel_l, bases_l;
    logic          ilace_l, hpol_l, vpol_l;

    // live registers written by software
    always_ff @(posedge clk) begin
        if (rst) begin
            htot_l  <= HW'(DEF_HTOT);  vtot_l  <= VW'(DEF_VTOT);
            hbs_l   <= HW'(DEF_HBS);   hbe_l   <= HW'(DEF_HBE);
            vbs_l   <= VW'(DEF_VBS);   vbe_l   <= VW'(DEF_VBE);
            hws_l   <= HW'(DEF_HWS);
            vw1_l   <= VW'(DEF_VWS);   vw2_l   <= VW'(DEF_VWS);
            words_l <= HW'(DEF_WORDS); lines_l <= VW'(DEF_LINES);
            mod_l   <= HW'(DEF_MOD);
            basel_l <= AW'(DEF_BASE_L); bases_l <= AW'(DEF_BASE_S);
            hsw_l   <= HW'(DEF_HSW);   vsw_l   <= VW'(DEF_VSW);
            en      <= 1'b0;
            ilace_l <= 1'b0; hpol_l <= 1'b0; vpol_l <= 1'b0;
        end else if (we) begin
            case (addr)
                4'(REG_HTOT):   htot_l <= wdata[HW-1:0];
                4'(REG_VTOT):   vtot_l <= wdata[VW-1:0];
                4'(REG_HBRD):   begin hbs_l <= wdata[HI_LSB +: HW]; hbe_l <= wdata[HW-1:0]; end
                4'(REG_VBRD):   begin vbs_l <= wdata[HI_LSB +: VW]; vbe_l <= wdata[VW-1:0]; end
                4'(REG_HWIN):   hws_l <= wdata[HW-1:0];
                4'(REG_VWIN):   begin vw2_l <= wdata[HI_LSB +: VW]; vw1_l <= wdata[VW-1:0]; end
                4'(REG_WORDS):  words_l <= wdata[HW-1:0];
                4'(REG_LINES):  lines_l <= wdata[VW-1:0];
                4'(REG_MOD):    mod_l <= wdata[HW-1:0];
                4'(REG_BASE_L): basel_l <= wdata[AW-1:0];
                4'(REG_BASE_S): bases_l <= wdata[AW-1:0];
                4'(REG_SYNCW):  begin vsw_l <= wdata[HI_LSB +: VW]; hsw_l <= wdata[HW-1:0]; end
                4'(REG_MODE): begin
                    en      <= wdata[MODE_EN];
                    ilace_l <= wdata[MODE_ILACE];
                    hpol_l  <= wdata[MODE_HPOL];
                    vpol_l  <= wdata[MODE_VPOL];
                end
                default: ;
            endcase
        end
    end

    // shadow copies, refreshed only on the frame boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            htot_s  <= HW'(DEF_HTOT);  vtot_s  <= VW'(DEF_VTOT);
            hbs_s   <= HW'(DEF_HBS);   hbe_s   <= HW'(DEF_HBE);
            vbs_s   <= VW'(DEF_VBS);   vbe_s   <= VW'(DEF_VBE);
            hws_s   <= HW'(DEF_HWS);
            vw1_s   <= VW'(DEF_VWS);   vw2_s   <= VW'(DEF_VWS);
            words_s <= HW'(DEF_WORDS); lines_s <= VW'(DEF_LINES);
            mod_s   <= HW'(DEF_MOD);
            basel_s <= AW'(DEF_BASE_L); bases_s <= AW'(DEF_BASE_S);
            hsw_s   <= HW'(DEF_HSW);   vsw_s   <= VW'(DEF_VSW);
            ilace_s <= 1'b0; hpol_s <= 1'b0; vpol_s <= 1'b0;
        end else if (frame_end) begin
            htot_s  <= htot_l;  vtot_s  <= vtot_l;
            hbs_s   <= hbs_l;   hbe_s   <= hbe_l;
            vbs_s   <= vbs_l;   vbe_s   <= vbe_l;
            hws_s   <= hws_l;
            vw1_s   <= vw1_l;   vw2_s   <= vw2_l;
            words_s <= words_l; lines_s <= lines_l;
            mod_s   <= mod_l;
            basel_s <= basel_l; bases_s <= bases_l;
            hsw_s   <= hsw_l;   vsw_s   <= vsw_l;
            ilace_s <= ilace_l; hpol_s  <= hpol_l; vpol_s <= vpol_l;
        end
    end

    // R10: shadows move only on a frame wrap
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(htot_s) && $stable(hws_s) && $stable(ilace_s) && $stable(mod_s)));
endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int HW = 10,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] htot,
    input  logic [VW-1:0] vtot,
    input  logic          ilace,
    output logic [HW-1:0] hc,
    output logic [VW-1:0] vc,
    output logic          field,
    output logic          line_end,
    output logic          frame_end
);
    assign line_end  = (hc == htot);
    assign frame_end = line_end && (vc == vtot);

    always_ff @(posedge clk) begin
        if (rst) begin
            hc    <= '0;
            vc    <= '0;
            field <= 1'b0;
        end else begin
            hc <= line_end ? '0 : hc + 1'b1;
            if (line_end)
                vc <= frame_end ? '0 : vc + 1'b1;
            if (frame_end)
                field <= ilace ? ~field : 1'b0;
        end
    end

    // R1: counters stay within their programmed totals
    p_hc_range_r1: assert property (@(posedge clk) disable iff (rst) hc <= htot && vc <= vtot);
    // R1: a line wrap inside a frame advances the line count by one
    p_vc_step_r1: assert property (@(posedge clk) disable iff (rst)
        (line_end && !frame_end) |=> vc == $past(vc) + 1'b1);
    // R8: field id changes only on a frame wrap
    p_field_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(field));
endmodule

// File: rtl/raster_fetch.sv
module raster_fetch
    import raster_pkg::*;
#(
    parameter int HW = 10,
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_win,
    input  logic          line_end,
    input  logic          frame_end,
    input  logic          en,
    input  logic          field,
    input  logic [HW-1:0] words,
    input  logic [HW-1:0] modulo,
    input  logic [AW-1:0] base_l,
    input  logic [AW-1:0] base_s,
    output logic          stb_o,
    output logic [AW-1:0] addr_o
);
    fetch_state_e  st, st_d;
    logic [HW-1:0] wctr, wctr_d;
    logic [AW-1:0] line_base, base_d, addr_d, start_addr;
    logic          fresh, fresh_d, stb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FS_IDLE;
            wctr      <= '0;
            line_base <= '0;
            fresh     <= 1'b1;
            stb_o     <= 1'b0;
            addr_o    <= '0;
        end else begin
            st        <= st_d;
            wctr      <= wctr_d;
            line_base <= base_d;
            fresh     <= fresh_d;
            stb_o     <= stb_d;
            addr_o    <= addr_d;
        end
    end

    always_comb begin
        st_d       = st;
        wctr_d     = wctr;
        base_d     = line_base;
        fresh_d    = fresh;
        stb_d      = 1'b0;
        addr_d     = addr_o;
        start_addr = fresh ? (field ? base_s : base_l) : line_base;
        unique case (st)
            FS_IDLE: if (in_win) begin
                stb_d   = en;
                addr_d  = start_addr;
                fresh_d = 1'b0;
                if (words == '0) begin
                    base_d = start_addr + AW'(modulo);
                    st_d   = FS_HOLD;
                end else begin
                    base_d = start_addr;
                    wctr_d = HW'(1);
                    st_d   = FS_BURST;
                end
            end
            FS_BURST: if (in_win) begin
                stb_d  = en;
                addr_d = line_base + AW'(wctr);
                if (wctr == words) begin
                    base_d = line_base + AW'(words) + AW'(modulo);
                    wctr_d = '0;
                    st_d   = FS_HOLD;
                end else begin
                    wctr_d = wctr + 1'b1;
                end
            end
            FS_HOLD: ;
            default: st_d = FS_IDLE;
        endcase
        if (line_end) begin
            st_d   = FS_IDLE;
            wctr_d = '0;
        end
        if (frame_end)
            fresh_d = 1'b1;
    end

    // R5: a burst only runs over contiguous window positions
    p_burst_in_win_r5: assert property (@(posedge clk) disable iff (rst)
        (st == FS_BURST) |-> in_win);
endmodule

// File: rtl/raster_fetch_gen.sv
module raster_fetch_gen
    import raster_pkg::*;
#(
    parameter int HW = 10,
    parameter int VW = 10,
    parameter int AW = 22,
    parameter int DEF_HTOT = 857,
    parameter int DEF_VTOT = 524,
    parameter int DEF_HBS = 126,
    parameter int DEF_HBE = 837,
    parameter int DEF_VBS = 40,
    parameter int DEF_VBE = 444,
    parameter int DEF_HWS = 164,
    parameter int DEF_VWS = 36,
    parameter int DEF_WORDS = 319,
    parameter int DEF_LINES = 479,
    parameter int DEF_MOD = 1,
    parameter int DEF_BASE_L = 0,
    parameter int DEF_BASE_S = 320,
    parameter int DEF_HSW = 64,
    parameter int DEF_VSW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          border_o,
    output logic          pixel_o,
    output logic          field_o,
    output logic          fetch_stb_o,
    output logic [AW-1:0] fetch_addr_o
);
    logic          en, ilace_s, hpol_s, vpol_s;
    logic [HW-1:0] htot_s, hbs_s, hbe_s, hws_s, words_s, mod_s, hsw_s;
    logic [VW-1:0] vtot_s, vbs_s, vbe_s, vw1_s, vw2_s, lines_s, vsw_s;
    logic [AW-1:0] basel_s, bases_s;
    logic [HW-1:0] hc;
    logic [VW-1:0] vc;
    logic          field, line_end, frame_end;

    raster_regs #(
        .HW(HW), .VW(VW), .AW(AW),
        .DEF_HTOT(DEF_HTOT), .DEF_VTOT(DEF_VTOT),
        .DEF_HBS(DEF_HBS), .DEF_HBE(DEF_HBE), .DEF_VBS(DEF_VBS), .DEF_VBE(DEF_VBE),
        .DEF_HWS(DEF_HWS), .DEF_VWS(DEF_VWS), .DEF_WORDS(DEF_WORDS), .DEF_LINES(DEF_LINES),
        .DEF_MOD(DEF_MOD), .DEF_BASE_L(DEF_BASE_L), .DEF_BASE_S(DEF_BASE_S),
        .DEF_HSW(DEF_HSW), .DEF_VSW(DEF_VSW)
    ) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .frame_end(frame_end), .en(en),
        .htot_s(htot_s), .vtot_s(vtot_s), .hbs_s(hbs_s), .hbe_s(hbe_s),
        .vbs_s(vbs_s), .vbe_s(vbe_s), .hws_s(hws_s), .vw1_s(vw1_s), .vw2_s(vw2_s),
        .words_s(words_s), .lines_s(lines_s), .mod_s(mod_s),
        .basel_s(basel_s), .bases_s(bases_s), .hsw_s(hsw_s), .vsw_s(vsw_s),
        .ilace_s(ilace_s), .hpol_s(hpol_s), .vpol_s(vpol_s)
    );

    raster_counter #(.HW(HW), .VW(VW)) u_cnt (
        .clk(clk), .rst(rst), .htot(htot_s), .vtot(vtot_s), .ilace(ilace_s),
        .hc(hc), .vc(vc), .field(field), .line_end(line_end), .frame_end(frame_end)
    );

    // window and border comparators
    logic [HW:0]   h_win_end;
    logic [VW:0]   v_win_end;
    logic [VW-1:0] v_start;
    logic          in_win, in_bord;

    always_comb begin
        v_start   = field ? vw2_s : vw1_s;
        h_win_end = {1'b0, hws_s} + {1'b0, words_s} + 1'b1;
        v_win_end = {1'b0, v_start} + {1'b0, lines_s} + 1'b1;
        in_win    = (hc >= hws_s) && ({1'b0, hc} < h_win_end) &&
                    (vc >= v_start) && ({1'b0, vc} < v_win_end);
        in_bord   = (hc >= hbs_s) && (hc < hbe_s) && (vc >= vbs_s) && (vc < vbe_s);
    end

    raster_fetch #(.HW(HW), .AW(AW)) u_fetch (
        .clk(clk), .rst(rst), .in_win(in_win), .line_end(line_end),
        .frame_end(frame_end), .en(en), .field(field),
        .words(words_s), .modulo(mod_s), .base_l(basel_s), .base_s(bases_s),
        .stb_o(fetch_stb_o), .addr_o(fetch_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_o  <= 1'b0;
            vsync_o  <= 1'b0;
            border_o <= 1'b0;
            pixel_o  <= 1'b0;
            field_o  <= 1'b0;
        end else begin
            hsync_o  <= (hc < hsw_s) ^ hpol_s;
            vsync_o  <= (vc < vsw_s) ^ vpol_s;
            border_o <= en && in_bord && !in_win;
            pixel_o  <= en && in_win;
            field_o  <= field;
        end
    end

    // R5: comparator window and fetch machine agree word for word
    p_pix_stb_r5: assert property (@(posedge clk) disable iff (rst) pixel_o == fetch_stb_o);
endmodule

// File: tb/raster_fetch_gen_test.sv
`timescale 1ns/1ps
module raster_fetch_gen_test;
    localparam int HT = 16;
    localparam int VT = 10;
    localparam int FR = HT * VT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        hsync_o, vsync_o, border_o, pixel_o, field_o, fetch_stb_o;
    logic [15:0] fetch_addr_o;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    raster_fetch_gen #(
        .HW(10), .VW(10), .AW(16),
        .DEF_HTOT(15), .DEF_VTOT(9),
        .DEF_HBS(1), .DEF_HBE(14), .DEF_VBS(1), .DEF_VBE(9),
        .DEF_HWS(4), .DEF_VWS(2), .DEF_WORDS(3), .DEF_LINES(3),
        .DEF_MOD(1), .DEF_BASE_L(256), .DEF_BASE_S(260),
        .DEF_HSW(2), .DEF_VSW(1)
    ) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .border_o(border_o), .pixel_o(pixel_o),
        .field_o(field_o), .fetch_stb_o(fetch_stb_o), .fetch_addr_o(fetch_addr_o)
    );

    typedef struct packed {
        logic [7:0]  v;
        logic [7:0]  h;
        logic        pix;
        logic        bord;
        logic        hs;
        logic        vs;
        logic        stb;
        logic [15:0] addr;
    } vec_t;

    // frame 1, defaults, display enabled (R1 R2 R3 R4 R5 R6)
    localparam vec_t VEC [10] = '{
        '{8'd0, 8'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{8'd2, 8'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100},
        '{8'd2, 8'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0103},
        '{8'd2, 8'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{8'd3, 8'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{8'd3, 8'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{8'd3, 8'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0104},
        '{8'd5, 8'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h010F},
        '{8'd6, 8'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{8'd9, 8'd14, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}
    };

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // wait until outputs show counter position (f, v, h)
    task automatic at(int f, int v, int h);
        int target;
        target = f * FR + v * HT + h;
        forever begin
            @(negedge clk);
            if (edges >= 1 && edges - 1 >= target) break;
        end
        if (edges - 1 != target) check("SEQ", "position", edges - 1, target);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic outs(string req, logic pix, logic bord, logic stb);
        check(req, "pixel", pixel_o, pix);
        check(req, "border", border_o, bord);
        check(req, "strobe", fetch_stb_o, stb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11", "outputs", {hsync_o, vsync_o, border_o, pixel_o, field_o, fetch_stb_o}, 0);
        rst = 1'b0;

        // frame 0: display disabled after reset (R9 R11)
        at(0, 2, 4);  outs("R9", 0, 0, 0);
        at(0, 3, 0);  check("R9", "hsync running", hsync_o, 1);
        wr(4'd12, 32'h1);

        // frame 1: table walk
        foreach (VEC[i]) begin
            at(1, int'(VEC[i].v), int'(VEC[i].h));
            outs("R4", VEC[i].pix, VEC[i].bord, VEC[i].stb);
            check("R2", "hsync", hsync_o, VEC[i].hs);
            check("R2", "vsync", vsync_o, VEC[i].vs);
            if (VEC[i].stb) check("R5", "addr", fetch_addr_o, VEC[i].addr);
        end

        // frame 2: wrap and base reload (R1 R7), then stage new settings
        at(2, 0, 0);  check("R1", "hsync at wrap", hsync_o, 1); check("R1", "vsync at wrap", vsync_o, 1);
        at(2, 2, 4);  check("R7", "addr reload", fetch_addr_o, 16'h0100);
        wr(4'd4, 32'd6);
        wr(4'd12, 32'h5);
        at(2, 3, 4);  outs("R10", 1, 0, 1);
        at(2, 4, 0);  check("R10", "hsync pol held", hsync_o, 1);

        // frame 3: new settings active (R10 R2)
        at(3, 3, 0);  check("R2", "hsync inverted", hsync_o, 0);
        at(3, 3, 3);  check("R2", "hsync idle inverted", hsync_o, 1);
        at(3, 3, 4);  outs("R10", 0, 1, 0);
        at(3, 3, 6);  outs("R10", 1, 0, 1); check("R6", "addr", fetch_addr_o, 16'h0104);
        wr(4'd4, 32'd4);
        wr(4'd5, 32'h0003_0002);
        wr(4'd8, 32'd5);
        wr(4'd10, 32'h0200);
        wr(4'd12, 32'h3);

        // frame 4: field 0 with modulo 5 (R6 R8)
        at(4, 0, 0);  check("R8", "field", field_o, 0);
        at(4, 2, 4);  check("R7", "addr", fetch_addr_o, 16'h0100);
        at(4, 3, 4);  check("R6", "addr", fetch_addr_o, 16'h0108);
        at(4, 5, 7);  check("R6", "addr", fetch_addr_o, 16'h011B);

        // frame 5: field 1 (R4 R7 R8)
        at(5, 0, 0);  check("R8", "field", field_o, 1);
        at(5, 2, 4);  outs("R4", 0, 1, 0);
        at(5, 3, 4);  outs("R4", 1, 0, 1); check("R7", "addr", fetch_addr_o, 16'h0200);
        at(5, 6, 5);  check("R6", "addr", fetch_addr_o, 16'h0219);

        // frame 6: field 0 again, then disable mid-frame (R8 R7 R9)
        at(6, 0, 0);  check("R8", "field", field_o, 0);
        at(6, 2, 4);  check("R7", "addr", fetch_addr_o, 16'h0100);
        wr(4'd12, 32'h2);
        at(6, 4, 5);  outs("R9", 0, 0, 0);
        at(6, 5, 0);  check("R9", "hsync running", hsync_o, 1);

        // reset mid-run restores defaults (R11 R12)
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "outputs", {hsync_o, vsync_o, border_o, pixel_o, field_o, fetch_stb_o}, 0);
        rst = 1'b0;
        at(0, 0, 0);  check("R1", "syncs at start", {hsync_o, vsync_o}, 2'b11);
        at(0, 2, 4);  outs("R11", 0, 0, 0);
        wr(4'd13, 32'hFFFF_FFFF);
        wr(4'd12, 32'h1);
        at(1, 2, 5);  outs("R12", 1, 0, 1); check("R11", "addr", fetch_addr_o, 16'h0101);
        at(1, 3, 0);  check("R12", "hsync pol", hsync_o, 1);
        at(1, 3, 4);  check("R11", "addr", fetch_addr_o, 16'h0104);
        at(2, 0, 0);  check("R8", "field", field_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule